// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the digital half of a PLL feedback divider that sits behind an external two-ratio prescaler. It runs on the prescaler's output clock. It holds a 4-bit swallow count A and a 15-bit main count M, and it drives a modulus-select line back to the prescaler. For the first A prescaler periods of every cycle it asks for the larger ratio N+1. For the rest it asks for N. After M prescaler periods the cycle closes and a one-period pulse appears on `div_out`. One output pulse therefore spans M·N + A input cycles, so a change of one in A moves the synthesised frequency by one comparison step.

Two terminal words are held at the ports, and `sel_w1` chooses which one is live. The selected word is copied into an internal staging register only while enough prescaler periods remain in the running cycle. The staged word is loaded into the counters at each cycle boundary. A change that arrives too close to the end is therefore held over, and it reaches the counters one cycle later. A mode input chooses the 8/9 ratio pair in place of 16/17. In that mode the top bit of A is ignored.

Top module: `dmd_fb_divider`

## Requirements
- R1: Between two consecutive rising edges of `div_out` there are exactly M·N + A input clock cycles. N is 16 when `mode8` = 0 and 8 when `mode8` = 1. A and M are the terminal values that were loaded at the start of that cycle.
- R2: Within a cycle, `mod_hi` (1 = ratio N+1, 0 = ratio N) is high for the first A prescaler periods and low for the remaining M−A. When A = 0 it stays low for the whole cycle.
- R3: `div_out` is high for exactly one prescaler period at the end of each cycle and low at all other times. This assumes M ≥ 2.
- R4: `sel_w1` = 1 selects word 1 (`w1_a`, `w1_m`), and `sel_w1` = 0 selects word 2. A change of selection or of the selected word never alters the cycle in progress. It takes effect from a cycle boundary.
- R5: The remaining count is the number of prescaler periods still to come in the cycle, counting the current one. On a prescaler edge where the remaining count is above 3, the selected word is staged for the next boundary. On an edge where it is 3 or less, the word is not staged, so a change made then reaches the counters one cycle later.
- R6: When `mode8` = 1, bit 3 of A is treated as 0. With A = 4'b1011 the cycle is 8·M + 3 input cycles.
- R7: `rst` is synchronous to `pre_clk`. While `rst` is high, `mod_hi` = 1 and `div_out` = 0. On each reset edge the selected word is loaded into the counters and the staging register, and the first cycle after release uses that word. `mode8` may change only while `rst` is high.
- R8: Legal words satisfy M ≥ A and M ≥ 4. The smallest fully usable ratio in 8/9 mode is 56 (M = 7, A = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk | input | 1 | Prescaler output clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode8 | input | 1 | 1 = 8/9 prescaler pair, 0 = 16/17 |
| sel_w1 | input | 1 | 1 = word 1 is live, 0 = word 2 |
| w1_a | input | 4 | Word 1 swallow count A |
| w1_m | input | 15 | Word 1 main count M |
| w2_a | input | 4 | Word 2 swallow count A |
| w2_m | input | 15 | Word 2 main count M |
| mod_hi | output | 1 | Modulus request: 1 = N+1, 0 = N |
| div_out | output | 1 | One-period pulse at every cycle end |

## Verification
The bench builds the block with its default parameters: a 4-bit A, a 15-bit M and a staging guard of 3 remaining periods. It uses M values between 7 and 40, so every cycle closes within a few hundred input clocks. At that size the bench reaches the guard boundary exactly, by changing a word when two periods remain. It also reaches the 8/9 masking of bit 3 of A, the minimum ratio of 56, and the A = 0 and A = M edges. The largest ratio is not run, because it would cost over half a million input clocks for each cycle.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int unsigned A_W = 4;
  localparam int unsigned M_W = 15;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [M_W-1:0] m;
  } div_word_t;
endpackage

// File: rtl/dmd_word_pick.sv
module dmd_word_pick
  import dmd_pkg::*;
(
  input  logic      sel_w1,
  input  logic      mode8,
  input  div_word_t w1,
  input  div_word_t w2,
  output div_word_t picked
);
  // live word, with the top A bit cleared in the short-ratio mode
  always_comb begin
    picked = sel_w1 ? w1 : w2;
    if (mode8) picked.a[A_W-1] = 1'b0;
  end
endmodule

// File: rtl/dmd_word_stage.sv
module dmd_word_stage
  import dmd_pkg::*;
#(
  parameter int unsigned HOLD_LIM = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode8,
  input  logic [M_W-1:0] m_rem,
  input  div_word_t      cand,
  output div_word_t      stage_q
);
  localparam logic [M_W-1:0] LIM = M_W'(HOLD_LIM);

  logic open_win;
  assign open_win = (m_rem > LIM);

  always_ff @(posedge clk) begin
    if (rst)           stage_q <= cand;
    else if (open_win) stage_q <= cand;
  end

  // R5
  hold_window_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rem <= LIM) |=> $stable(stage_q));

  // R4
  stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rem > LIM) |=> (stage_q == $past(cand)));

  // R6
  short_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst && mode8) |-> (stage_q.a[A_W-1] == 1'b0));
endmodule

// File: rtl/dmd_count_core.sv
module dmd_count_core
  import dmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  div_word_t      reload_w,
  output logic [M_W-1:0] m_rem,
  output logic           mod_hi,
  output logic           div_q
);
  logic [A_W-1:0] a_rem;
  logic           at_end;

  assign at_end = (m_rem == M_W'(1));
  assign mod_hi = rst | (a_rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rem <= reload_w.m;
      a_rem <= reload_w.a;
      div_q <= 1'b0;
    end else if (at_end) begin
      m_rem <= reload_w.m;
      a_rem <= reload_w.a;
      div_q <= 1'b1;
    end else begin
      m_rem <= m_rem - 1'b1;
      if (a_rem != '0) a_rem <= a_rem - 1'b1;
      div_q <= 1'b0;
    end
  end

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (m_rem == M_W'(1)) |=> (m_rem == $past(reload_w.m)));

  // R2
  low_ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_rem == '0) && (m_rem != M_W'(1))) |=> !mod_hi);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    div_q |=> !div_q);
endmodule

// File: rtl/dmd_fb_divider.sv
module dmd_fb_divider
  import dmd_pkg::*;
#(
  parameter int unsigned HOLD_LIM = 3
) (
  input  logic           pre_clk,
  input  logic           rst,
  input  logic           mode8,
  input  logic           sel_w1,
  input  logic [A_W-1:0] w1_a,
  input  logic [M_W-1:0] w1_m,
  input  logic [A_W-1:0] w2_a,
  input  logic [M_W-1:0] w2_m,
  output logic           mod_hi,
  output logic           div_out
);
  div_word_t      w1, w2, cand, staged, reload_w;
  logic [M_W-1:0] m_rem;

  assign w1 = '{a: w1_a, m: w1_m};
  assign w2 = '{a: w2_a, m: w2_m};

  dmd_word_pick u_pick (
    .sel_w1 (sel_w1),
    .mode8  (mode8),
    .w1     (w1),
    .w2     (w2),
    .picked (cand)
  );

  dmd_word_stage #(.HOLD_LIM(HOLD_LIM)) u_stage (
    .clk     (pre_clk),
    .rst     (rst),
    .mode8   (mode8),
    .m_rem   (m_rem),
    .cand    (cand),
    .stage_q (staged)
  );

  // reset loads the live word directly; otherwise the staged copy
  assign reload_w = rst ? cand : staged;

  dmd_count_core u_core (
    .clk      (pre_clk),
    .rst      (rst),
    .reload_w (reload_w),
    .m_rem    (m_rem),
    .mod_hi   (mod_hi),
    .div_q    (div_out)
  );

  // R2
  first_period_chk: assert property (@(posedge pre_clk) disable iff (rst)
    div_out |-> (mod_hi == (staged.a != '0)));
endmodule

// File: tb/sim_dmd_fb_divider.sv
module sim_dmd_fb_divider;
  logic rf_clk = 1'b0;
  always #5 rf_clk = ~rf_clk;

  logic        pre_clk = 1'b0;
  logic        rst = 1'b1, mode8 = 1'b0, sel_w1 = 1'b1;
  logic [3:0]  w1_a = 4'd0, w2_a = 4'd0;
  logic [14:0] w1_m = 15'd8, w2_m = 15'd8;
  logic        mod_hi, div_out;

  dmd_fb_divider u0 (
    .pre_clk(pre_clk), .rst(rst), .mode8(mode8), .sel_w1(sel_w1),
    .w1_a(w1_a), .w1_m(w1_m), .w2_a(w2_a), .w2_m(w2_m),
    .mod_hi(mod_hi), .div_out(div_out)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic void chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // behavioural prescaler on the input clock
  int pcnt = 0, ratio = 17;
  always @(posedge rf_clk) begin
    if (pcnt == ratio - 1) begin
      pcnt <= 0;
      pre_clk <= 1'b1;
    end else begin
      if (pcnt == 0) ratio <= mod_hi ? (mode8 ? 9 : 17) : (mode8 ? 8 : 16);
      pcnt <= pcnt + 1;
      pre_clk <= 1'b0;
    end
  end

  // reference model, one step per prescaler period
  int mrem = 0, arem = 0, stA = 0, stM = 0, curA = 0, curM = 0;
  bit exp_div = 0;
  int exp_q[$];

  always @(posedge pre_clk) begin
    int selA, selM;
    selA = sel_w1 ? int'(w1_a) : int'(w2_a);
    if (mode8) selA = selA % 8;
    selM = sel_w1 ? int'(w1_m) : int'(w2_m);
    if (rst) begin
      stA = selA; stM = selM; curA = selA; curM = selM;
      mrem = selM; arem = selA; exp_div = 0;
      exp_q.delete();
    end else if (mrem == 1) begin
      exp_q.push_back(curM * (mode8 ? 8 : 16) + curA);
      curA = stA; curM = stM; mrem = stM; arem = stA; exp_div = 1;
    end else begin
      if (mrem > 3) begin stA = selA; stM = selM; end
      mrem--;
      if (arem > 0) arem--;
      exp_div = 0;
    end
  end

  // per-clock comparison and period measurement
  longint rfcnt = 0, last_rise = 0, last_period = 0;
  int pulse_cnt = 0;
  bit have_prev = 0, div_d = 0;

  always @(negedge rf_clk) begin
    rfcnt++;
    if (rst) begin
      have_prev = 0;
      // R7: reset forces the high ratio and no output pulse
      if (pre_clk) begin
        chk(mod_hi == 1'b1, "R7 mod_hi in reset", mod_hi, 1);
        chk(div_out == 1'b0, "R7 div_out in reset", div_out, 0);
      end
    end else if (pre_clk) begin
      chk(mod_hi == (arem != 0), "R2 modulus", mod_hi, arem != 0);
      chk(div_out == exp_div, "R3 pulse", div_out, exp_div);
    end
    if (!rst && div_out && !div_d) begin
      int e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      if (have_prev) begin
        last_period = rfcnt - last_rise;
        // R1: period matches M*N+A of the cycle just closed
        chk(last_period == e, "R1 period", last_period, e);
      end
      have_prev = 1;
      last_rise = rfcnt;
      pulse_cnt++;
    end
    div_d = div_out;
  end

  task automatic step();
    @(posedge rf_clk);
    #2;
  endtask

  task automatic wait_pulses(int n);
    int target;
    target = pulse_cnt + n;
    wait (pulse_cnt >= target);
    step();
  endtask

  task automatic do_reset(bit m8, bit s1);
    step();
    rst = 1'b1; mode8 = m8; sel_w1 = s1;
    repeat (4) @(posedge pre_clk);
    step();
    rst = 1'b0;
  endtask

  task automatic expect_next(longint exp, string req);
    wait_pulses(1);
    chk(last_period == exp, req, last_period, exp);
  endtask

  initial begin
    repeat (190000) @(posedge rf_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R7: reset loads word 1, first full cycle uses it
    w1_a = 4'd3; w1_m = 15'd12; w2_a = 4'd0; w2_m = 15'd9;
    do_reset(1'b0, 1'b1);
    wait_pulses(1);
    expect_next(195, "R7 first word after reset");

    // R4: early change applies only from the next boundary
    w1_a = 4'd5; w1_m = 15'd20;
    expect_next(195, "R4 current cycle unchanged");
    expect_next(325, "R4 new word at boundary");

    // R5: change with two periods left is deferred one cycle
    wait (mrem == 2);
    step();
    w1_a = 4'd2; w1_m = 15'd10;
    expect_next(325, "R5 late change ignored this cycle");
    expect_next(325, "R5 late change deferred");
    expect_next(162, "R5 late change applied");

    // R4: selection of word 2
    w2_a = 4'd7; w2_m = 15'd9;
    sel_w1 = 1'b0;
    expect_next(162, "R4 select held until boundary");
    expect_next(151, "R4 word 2 live");

    // R2: A = 0 and A = M
    w2_a = 4'd0; w2_m = 15'd8;
    expect_next(151, "R2 previous word");
    expect_next(128, "R2 A zero");
    w2_a = 4'd9; w2_m = 15'd9;
    expect_next(128, "R2 previous word");
    expect_next(153, "R2 A equal M");

    // R6: 8/9 mode masks bit 3 of A
    w1_a = 4'b1011; w1_m = 15'd9;
    do_reset(1'b1, 1'b1);
    wait_pulses(1);
    expect_next(75, "R6 masked A");

    // R8: minimum usable ratio 56
    w1_a = 4'd0; w1_m = 15'd7;
    expect_next(75, "R8 previous word");
    expect_next(56, "R8 minimum ratio");

    // random legal words in both modes, checked by the model (R1, R2, R3)
    for (int md = 0; md < 2; md++) begin
      do_reset(md[0], 1'b1);
      for (int i = 0; i < 10; i++) begin
        int m, a;
        m = md ? $urandom_range(8, 40) : $urandom_range(15, 40);
        a = $urandom_range(0, 15);
        repeat ($urandom_range(0, 400)) step();
        if ($urandom_range(0, 1) == 1) begin
          w1_a = 4'(a); w1_m = 15'(m);
        end else begin
          w2_a = 4'(a); w2_m = 15'(m);
        end
        sel_w1 = 1'($urandom_range(0, 1));
        wait_pulses(2);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule